// File: doc/BRIEF.md
# Bit-Serial Adder with Start/Done Handshake

This block adds two unsigned operands of a configurable width by handling a single bit pair per clock. When a start request is seen while the block is idle, both operands are captured in parallel into shift registers. A carry machine then walks the operand bits from least significant to most significant. It emits one sum bit per cycle, and that bit is shifted into a result register. Once every bit pair has been consumed the block raises done and keeps the result steady. It will not accept another request until start has been deasserted.

The carry machine can be built in one of two variants, chosen by a parameter. In the first, the sum bit is a combinational function of the carry flop and the current operand bits. In the second, the sum bit passes through an extra output flop, so the block runs one cycle longer to flush that stage. Both variants leave the same final value in the result register.

Top module: `sadd_top`

## Requirements
- R1: While rstN is low, and in the cycle after it is released, done is 0 and sum is all zeros.
- R2: With MOORE=0, a start of 1 seen at a clock edge in the idle state captures opA and opB, and done becomes 1 exactly WIDTH clock edges after that capture edge.
- R3: With MOORE=1, done becomes 1 exactly WIDTH+1 clock edges after the capture edge.
- R4: When done is 1, sum equals (opA + opB) mod 2^WIDTH, using the values captured at the capture edge. The carry out of the top bit is discarded.
- R5: While done is 1 and start stays 1, done stays 1 and sum does not change.
- R6: A start of 0 seen at an edge while done is 1 returns the block to idle, and done is 0 after that edge.
- R7: Changes on opA and opB after the capture edge have no effect on the result.
- R8: Start dropping to 0 during an addition does not stop the addition. Done then rises on schedule for one cycle.
- R9: The carry state is cleared at every capture, so a carry left over from the previous addition never enters the next one.
- R10: Outside an addition, sum keeps the last result, whatever opA, opB and start do, until the next addition shifts into it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to add; must return to 0 before the next request |
| opA | input | WIDTH | First operand, captured at the start edge |
| opB | input | WIDTH | Second operand, captured at the start edge |
| sum | output | WIDTH | Result register, least significant bit shifted in first |
| done | output | 1 | High after the last bit pair, until start is released |

## Verification
The bench targets additions whose carry ripples through every bit, such as all ones plus one. A core that loses the carry, or misorders it, would show a wrong upper sum there. Such an addition is followed directly by zero plus zero. A core that fails to clear the carry at capture would return one instead of zero. Both variants run side by side, and done is compared on every cycle, so an off-by-one count or a missing flush cycle in the registered variant shows up as done moving a cycle early or late. Operands change in the middle of an addition, and start is dropped early or held long. A design that reads live operands or stalls on start would show a wrong result or a missing done pulse.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ADD  = 2'd1,
    SEQ_HOLD = 2'd2
  } seqState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;
    logic shift;
  } dpCtrl_t;

endpackage

// File: rtl/sadd_ctrl.sv
module sadd_ctrl
  import sadd_pkg::*;
#(
  parameter int LAT = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output dpCtrl_t dpCtrl,
  output logic    done
);

  localparam int CW = $clog2(LAT + 1);

  seqState_t state, stateNext;
  logic [CW-1:0] cnt;

  always_comb begin
    stateNext    = state;
    dpCtrl.load  = 1'b0;
    dpCtrl.shift = 1'b0;
    unique case (state)
      SEQ_IDLE: begin
        if (start) begin
          dpCtrl.load = 1'b1;
          stateNext   = SEQ_ADD;
        end
      end
      SEQ_ADD: begin
        dpCtrl.shift = 1'b1;
        if (cnt == CW'(1)) stateNext = SEQ_HOLD;
      end
      SEQ_HOLD: begin
        if (!start) stateNext = SEQ_IDLE;
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      if (dpCtrl.load)       cnt <= CW'(LAT);
      else if (dpCtrl.shift) cnt <= cnt - CW'(1);
    end
  end

  assign done = (state == SEQ_HOLD);

endmodule

// File: rtl/sadd_datapath.sv
module sadd_datapath
  import sadd_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          dpCtrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sum
);

  logic [WIDTH-1:0] aReg, bReg, sumReg;
  logic carry, carryNext, aBit, bBit, sBit;

  assign aBit      = aReg[0];
  assign bBit      = bReg[0];
  assign carryNext = (aBit & bBit) | (aBit & carry) | (bBit & carry);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg   <= '0;
      bReg   <= '0;
      sumReg <= '0;
      carry  <= 1'b0;
    end else if (dpCtrl.load) begin
      aReg  <= opA;
      bReg  <= opB;
      carry <= 1'b0;
    end else if (dpCtrl.shift) begin
      aReg   <= {1'b0, aReg[WIDTH-1:1]};
      bReg   <= {1'b0, bReg[WIDTH-1:1]};
      sumReg <= {sBit, sumReg[WIDTH-1:1]};
      carry  <= carryNext;
    end
  end

  generate
    if (MOORE) begin : g_moore
      logic y1;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             y1 <= 1'b0;
        else if (dpCtrl.load)  y1 <= 1'b0;
        else if (dpCtrl.shift) y1 <= aBit ^ bBit ^ carry;
      end
      assign sBit = y1;
    end else begin : g_mealy
      assign sBit = aBit ^ bBit ^ carry;
    end
  endgenerate

  assign sum = sumReg;

endmodule

// File: rtl/sadd_top.sv
module sadd_top
  import sadd_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sum,
  output logic             done
);

  localparam int LAT = MOORE ? WIDTH + 1 : WIDTH;

  dpCtrl_t dpCtrl;

  sadd_ctrl #(.LAT(LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .dpCtrl(dpCtrl), .done(done)
  );

  sadd_datapath #(.WIDTH(WIDTH), .MOORE(MOORE)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .opA(opA), .opB(opB), .sum(sum)
  );

endmodule

// File: rtl/sadd_checker.sv
module sadd_checker #(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [WIDTH-1:0] sum,
  input logic             done
);

  localparam int LAT = MOORE ? WIDTH + 1 : WIDTH;
  localparam int CW  = $clog2(LAT + 2);

  logic busy;
  logic [CW-1:0] cnt;
  logic [WIDTH-1:0] expSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      expSum <= '0;
    end else if (!busy && !done && start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      expSum <= opA + opB;
    end else if (busy && !done) begin
      cnt <= cnt + CW'(1);
    end else if (busy && done) begin
      busy <= 1'b0;
    end
  end

  // R2 / R3: done rises exactly LAT edges after capture
  a_r2_done_timing: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (busy && cnt == CW'(LAT)));

  a_r3_no_early_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt < CW'(LAT)) |-> !done);

  a_r4_result: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (sum == expSum));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> (done && $stable(sum)));

  a_r6_release: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !done);

  a_r10_sum_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(sum));

endmodule

bind sadd_top sadd_checker #(.WIDTH(WIDTH), .MOORE(MOORE)) u_chk (.*);

// File: tb/test_sadd_top.sv
module test_sadd_top;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [WIDTH-1:0] opA = '0;
  logic [WIDTH-1:0] opB = '0;
  logic [WIDTH-1:0] sumMealy, sumMoore;
  logic doneMealy, doneMoore;

  always #(CLK_PERIOD/2) clk = ~clk;

  sadd_top #(.WIDTH(WIDTH), .MOORE(1'b0)) i_sadd_top (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .sum(sumMealy), .done(doneMealy)
  );

  sadd_top #(.WIDTH(WIDTH), .MOORE(1'b1)) i_sadd_top_moore (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .sum(sumMoore), .done(doneMoore)
  );

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R1";

  // behavioural reference: 0 idle, 1 adding, 2 done
  int mState[2];
  int mCnt[2];
  logic [WIDTH-1:0] mA[2], mB[2], mSum[2];

  function automatic int latOf(int v);
    return (v == 1) ? WIDTH + 1 : WIDTH;
  endfunction

  task automatic modelStep();
    for (int v = 0; v < 2; v++) begin
      if (!rstN) begin
        mState[v] = 0; mCnt[v] = 0; mSum[v] = '0;
      end else begin
        case (mState[v])
          0: if (start) begin
               mA[v] = opA; mB[v] = opB; mCnt[v] = latOf(v); mState[v] = 1;
             end
          1: begin
               mCnt[v] = mCnt[v] - 1;
               if (mCnt[v] == 0) begin
                 mState[v] = 2;
                 mSum[v] = mA[v] + mB[v];
               end
             end
          default: if (!start) mState[v] = 0;
        endcase
      end
    end
  endtask

  task automatic compare();
    for (int v = 0; v < 2; v++) begin
      logic [WIDTH-1:0] s;
      logic d, expD;
      string tag;
      s = (v == 1) ? sumMoore : sumMealy;
      d = (v == 1) ? doneMoore : doneMealy;
      tag = (v == 1) ? "moore" : "mealy";
      expD = (mState[v] == 2);
      vectors++;
      if (d !== expD) begin
        miscompares++;
        $display("FAIL %s (%s) done: actual=%b expected=%b at %0t",
                 curReq, tag, d, expD, $time);
      end
      if (mState[v] != 1) begin
        vectors++;
        if (s !== mSum[v]) begin
          miscompares++;
          $display("FAIL %s (%s) sum: actual=%h expected=%h at %0t",
                   curReq, tag, s, mSum[v], $time);
        end
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compare();
  endtask

  task automatic doAdd(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                       input int extraHold, input bit scramble);
    opA = a; opB = b; start = 1'b1;
    tick();
    if (scramble) begin
      opA = ~a; opB = a ^ b ^ 8'h3C;
    end
    repeat (WIDTH + 1 + extraHold) tick();
    start = 1'b0;
    repeat (2) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL %s watchdog: actual=hung expected=finished", curReq);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int v = 0; v < 2; v++) begin
      mState[v] = 0; mCnt[v] = 0; mSum[v] = '0; mA[v] = '0; mB[v] = '0;
    end
    // R1: reset state
    curReq = "R1";
    @(negedge clk);
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    curReq = "R2";
    doAdd(8'd3, 8'd4, 0, 1'b0);
    doAdd(8'h5A, 8'h25, 0, 1'b0);
    doAdd(8'h00, 8'h00, 0, 1'b0);

    curReq = "R3";
    doAdd(8'h81, 8'h7F, 0, 1'b0);
    doAdd(8'h12, 8'h34, 1, 1'b0);

    curReq = "R4";
    doAdd(8'hFF, 8'h01, 0, 1'b0);
    doAdd(8'hFF, 8'hFF, 0, 1'b0);
    doAdd(8'h80, 8'h80, 0, 1'b0);

    curReq = "R5";
    doAdd(8'h6B, 8'h2E, 6, 1'b1);

    curReq = "R6";
    doAdd(8'h0F, 8'hF0, 0, 1'b0);

    curReq = "R7";
    doAdd(8'hC3, 8'h5D, 0, 1'b1);
    doAdd(8'h01, 8'h01, 2, 1'b1);

    // R9: carry left over from a full-ripple add must not leak
    curReq = "R9";
    doAdd(8'hFF, 8'h01, 0, 1'b0);
    doAdd(8'h00, 8'h00, 0, 1'b0);
    doAdd(8'hFF, 8'hFF, 0, 1'b0);
    doAdd(8'h01, 8'h00, 0, 1'b0);

    // R8: start pulse of one cycle
    curReq = "R8";
    opA = 8'h77; opB = 8'h19; start = 1'b1;
    tick();
    start = 1'b0;
    repeat (WIDTH + 4) tick();

    // R10: idle with busy operand inputs
    curReq = "R10";
    for (int i = 0; i < 6; i++) begin
      opA = 8'(i * 37 + 5); opB = 8'(i * 91 + 2);
      tick();
    end

    curReq = "R4";
    for (int i = 0; i < 20; i++) begin
      doAdd(8'($urandom), 8'($urandom), i % 3, i[0]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule